// File: doc/BRIEF.md
# Wake-Capable GPIO Port Bank

A bank of general-purpose pins behind a simple register interface. Each pin is set on its own as an input or an output. An output chooses how it drives the pad: actively in both directions, only low (open-drain), or not at all. An output can also be made to let go of its pad whenever a power-loss warning is raised. An input can turn on a pull-up. Each pin has a lock bit. Once the lock bit is set, the pin's configuration and its output data bit stop taking writes, and the lock stays set until reset.

Every pin is synchronised and then debounced by a small per-pin state machine. The debounce FSM has two states. `DB_STEADY` holds the accepted level; from there `start` leads to `DB_SETTLE` when the sampled level differs and the required run is two samples or more. If the required run is one sample or less, `DB_STEADY` accepts the new level at once. `DB_SETTLE` counts the run. `abort` returns to `DB_STEADY` when the sample falls back to the accepted level, and `accept` returns to `DB_STEADY` with the new level once the run is long enough. All pins except the top one are wake sources. Each wake source has a two-state status FSM. `EV_IDLE` goes to `EV_PENDING` on `trigger`, and `EV_PENDING` goes back to `EV_IDLE` on `clear`, which is a write-one-to-clear that arrives with no trigger in the same cycle. The trigger is the level-or-edge condition, taken after a polarity select. Each pending status is routed to two outputs, an interrupt request and a power-management event, and each route has its own enable.

Pads are modelled as output-enable, output-value and pull-up-enable signals. The host writes through a one-cycle write strobe and reads combinationally.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset, every configuration word, the output data word and the status word read 0, and `pad_oe`, `pad_pu`, `irq` and `pme` are all 0.
- R2: A pin's configuration bit 0 selects output (1) or input (0). An input never drives its pad. For an output, the 2-bit drive code in bits 2:1 works as follows. Code 0 (push-pull) gives `pad_oe`=1 and `pad_out` equal to the pin's data bit. Code 1 (open-drain) gives `pad_oe` equal to the inverse of the data bit and `pad_out`=0. Codes 2 and 3 (float) give `pad_oe`=0.
- R3: `pad_pu` for a pin equals its pull-up bit (bit 3) while the pin is an input, and is 0 while the pin is an output.
- R4: While `supply_fail` is 1, an output whose float-on-fail bit (bit 4) is set has `pad_oe`=0. An output without that bit keeps driving.
- R5: Writing a configuration word with bit 5 set locks that pin. After that, writes to its configuration word and to its bit of the data word are ignored, the lock cannot be cleared by a write, and only reset unlocks the pin.
- R6: Debounce is set by bits 15:12 (N). A level held on `pin_in` from before rising edge k shows in the level register after edge k+max(N,1)+1 and not before. A pulse lasting fewer than max(N,1) cycles is never accepted.
- R7: In level mode (bit 7 = 0), a wake pin's status is set in every cycle in which its debounced level XOR its polarity bit (bit 6) is 1. While that value is 0, the status stays clear.
- R8: In edge mode (bit 7 = 1), status is set only on a 0-to-1 change of (level XOR polarity). Holding the active level after a clear does not set it again.
- R9: Status bits are sticky. Writing 1 to a bit of the status word clears it, and writing 0 leaves it. A trigger in the same cycle as a clear wins.
- R10: `irq` is the OR of all status bits whose interrupt enable (bit 8) is set. `pme` is the OR of all status bits whose event enable (bit 9) is set.
- R11: The top pin (pin 15 by default) is not a wake source. Its status bit reads 0 whatever its configuration and input.
- R12: The register map is as follows. The configuration word of pin i is at address i. The output data word is at NPINS, the status word at NPINS+1 and the debounced level word at NPINS+2. Configuration bits 11:10 read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Combinational read data |
| pin_in | input | NPINS | Raw pad input levels |
| supply_fail | input | 1 | Main-supply falling warning |
| pad_oe | output | NPINS | Pad output enable per pin |
| pad_out | output | NPINS | Pad output value per pin |
| pad_pu | output | NPINS | Pad pull-up enable per pin |
| irq | output | 1 | Interrupt request from enabled pending events |
| pme | output | 1 | Power-management event from enabled pending events |

## Verification
The bench uses the default parameters: sixteen pins, a 4-bit debounce field and a wake mask that leaves out pin 15. With sixteen pins, every drive code, both data values, the pull-up and the float-on-fail bits can be swept on every pin. The 4-bit field is small enough that every debounce length from 0 to 15 is timed to the exact edge and tested with a pulse one cycle too short. Every wake pin is driven through all four polarity and mode combinations with mixed routing enables, and the one non-wake pin shows that the mask holds.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;

    localparam int CFG_W = 16;
    localparam int DBN_W = 4;

    typedef enum logic [1:0] {
        DRV_PUSHPULL  = 2'b00,
        DRV_OPENDRAIN = 2'b01,
        DRV_FLOAT     = 2'b10,
        DRV_FLOAT_ALT = 2'b11
    } drive_e;

    // Per-pin configuration word, MSB first.
    typedef struct packed {
        logic [DBN_W-1:0] dbn;      // debounce run length
        logic [1:0]       rsvd;     // reads 0
        logic             pme_en;
        logic             irq_en;
        logic             edge_md;  // 1: edge, 0: level
        logic             pol;      // 1: active low
        logic             lock;
        logic             flt;      // float on supply fail
        logic             pu;
        drive_e           drv;
        logic             dir;      // 1: output
    } pin_cfg_t;

    typedef enum logic { DB_STEADY, DB_SETTLE } db_state_e;
    typedef enum logic { EV_IDLE, EV_PENDING } ev_state_e;

    function automatic pin_cfg_t cfg_clean(input logic [CFG_W-1:0] w);
        pin_cfg_t c;
        c      = pin_cfg_t'(w);
        c.rsvd = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpio_wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [DBN_W-1:0] need,
    output logic             level
);

    logic             sync1, smp;
    db_state_e        st, st_n;
    logic [DBN_W-1:0] cnt, cnt_n;
    logic             lvl_n;
    logic [DBN_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + (DBN_W+1)'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            smp   <= 1'b0;
            st    <= DB_STEADY;
            cnt   <= '0;
            level <= 1'b0;
        end else begin
            sync1 <= pin;
            smp   <= sync1;
            st    <= st_n;
            cnt   <= cnt_n;
            level <= lvl_n;
        end
    end

    // Transitions: start, abort, accept
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        lvl_n = level;
        unique case (st)
            DB_STEADY: begin
                if (smp != level) begin
                    if (need <= DBN_W'(1)) begin
                        lvl_n = smp;
                    end else begin
                        cnt_n = DBN_W'(1);
                        st_n  = DB_SETTLE;
                    end
                end
            end
            DB_SETTLE: begin
                if (smp == level) begin
                    st_n = DB_STEADY;
                end else if (cnt_inc >= {1'b0, need}) begin
                    lvl_n = smp;
                    st_n  = DB_STEADY;
                end else begin
                    cnt_n = cnt_inc[DBN_W-1:0];
                end
            end
        endcase
    end

endmodule

// File: rtl/gpio_event.sv
module gpio_event
    import gpio_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic pol,
    input  logic edge_md,
    input  logic clr,
    output logic pending
);

    ev_state_e st, st_n;
    logic      act, act_q, trig;

    assign act  = level ^ pol;
    assign trig = edge_md ? (act & ~act_q) : act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= EV_IDLE;
            act_q <= 1'b0;
        end else begin
            st    <= st_n;
            act_q <= act;
        end
    end

    // Transitions: trigger, clear
    always_comb begin
        st_n = st;
        unique case (st)
            EV_IDLE:    if (trig)         st_n = EV_PENDING;
            EV_PENDING: if (clr && !trig) st_n = EV_IDLE;
        endcase
    end

    assign pending = (st == EV_PENDING);

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_wake_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     dat,
    input  logic     supply_fail,
    output logic     oe,
    output logic     out,
    output logic     pu
);

    always_comb begin
        oe  = 1'b0;
        out = 1'b0;
        if (cfg.dir && !(cfg.flt && supply_fail)) begin
            unique case (cfg.drv)
                DRV_PUSHPULL:  begin oe = 1'b1; out = dat;  end
                DRV_OPENDRAIN: begin oe = ~dat; out = 1'b0; end
                DRV_FLOAT, DRV_FLOAT_ALT: begin oe = 1'b0; out = 1'b0; end
            endcase
        end
    end

    assign pu = cfg.pu & ~cfg.dir;

endmodule

// File: rtl/gpio_wake_bank.sv
// NPINS must not exceed the 16-bit register width.
module gpio_wake_bank
    import gpio_wake_pkg::*;
#(
    parameter int               NPINS    = 16,
    parameter logic [NPINS-1:0] EVT_MASK = {1'b0, {(NPINS-1){1'b1}}},
    localparam int              AW       = $clog2(NPINS + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [CFG_W-1:0] rd_data,
    input  logic [NPINS-1:0] pin_in,
    input  logic             supply_fail,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu,
    output logic             irq,
    output logic             pme
);

    localparam logic [AW-1:0] A_DATA = AW'(NPINS);
    localparam logic [AW-1:0] A_STAT = AW'(NPINS + 1);
    localparam logic [AW-1:0] A_LVL  = AW'(NPINS + 2);

    logic [NPINS*CFG_W-1:0] cfg_flat;
    logic [NPINS-1:0]       lock_v, dir_v, flt_v, ien_v, pen_v;
    logic [NPINS-1:0]       lvl_v, stat_v, dout_q;
    logic                   stat_wr;

    assign stat_wr = wr_en && (wr_addr == A_STAT);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t cfg_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_r <= '0;
            else if (wr_en && wr_addr == AW'(i) && !cfg_r.lock)
                cfg_r <= cfg_clean(wr_data);
        end

        assign cfg_flat[i*CFG_W +: CFG_W] = cfg_r;
        assign lock_v[i] = cfg_r.lock;
        assign dir_v[i]  = cfg_r.dir;
        assign flt_v[i]  = cfg_r.flt;
        assign ien_v[i]  = cfg_r.irq_en;
        assign pen_v[i]  = cfg_r.pme_en;

        gpio_debounce u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[i]),
            .need  (cfg_r.dbn),
            .level (lvl_v[i])
        );

        gpio_pad_ctl u_pad (
            .cfg         (cfg_r),
            .dat         (dout_q[i]),
            .supply_fail (supply_fail),
            .oe          (pad_oe[i]),
            .out         (pad_out[i]),
            .pu          (pad_pu[i])
        );

        if (EVT_MASK[i]) begin : g_evt
            gpio_event u_ev (
                .clk     (clk),
                .rst_n   (rst_n),
                .level   (lvl_v[i]),
                .pol     (cfg_r.pol),
                .edge_md (cfg_r.edge_md),
                .clr     (stat_wr && wr_data[i]),
                .pending (stat_v[i])
            );
        end else begin : g_noevt
            assign stat_v[i] = 1'b0;
        end
    end

    // Output data word; bits of locked pins keep their value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout_q <= '0;
        else if (wr_en && wr_addr == A_DATA)
            dout_q <= (wr_data[NPINS-1:0] & ~lock_v) | (dout_q & lock_v);
    end

    assign irq = |(stat_v & ien_v);
    assign pme = |(stat_v & pen_v);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPINS; i++)
            if (rd_addr == AW'(i)) rd_data = cfg_flat[i*CFG_W +: CFG_W];
        if (rd_addr == A_DATA) rd_data = CFG_W'(dout_q);
        if (rd_addr == A_STAT) rd_data = CFG_W'(stat_v);
        if (rd_addr == A_LVL)  rd_data = CFG_W'(lvl_v);
    end

endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk
    import gpio_wake_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int AW    = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [AW-1:0]          wr_addr,
    input logic [CFG_W-1:0]       wr_data,
    input logic                   supply_fail,
    input logic [NPINS-1:0]       pad_oe,
    input logic                   irq,
    input logic                   pme,
    input logic [NPINS-1:0]       lock_v,
    input logic [NPINS-1:0]       dir_v,
    input logic [NPINS-1:0]       flt_v,
    input logic [NPINS-1:0]       stat_v,
    input logic [NPINS*CFG_W-1:0] cfg_flat
);

    localparam logic [AW-1:0] A_STAT = AW'(NPINS + 1);

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            lock_v[i] |=> lock_v[i]);

        p_lock_cfg_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
            lock_v[i] |=> $stable(cfg_flat[i*CFG_W +: CFG_W]));

        p_input_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !dir_v[i] |-> !pad_oe[i]);

        p_float_on_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_v[i] && supply_fail) |-> !pad_oe[i]);

        p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_v[i] && !(wr_en && wr_addr == A_STAT && wr_data[i])) |=> stat_v[i]);
    end

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_v != '0));

    p_pme_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pme |-> (stat_v != '0));

endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .supply_fail (supply_fail),
    .pad_oe      (pad_oe),
    .irq         (irq),
    .pme         (pme),
    .lock_v      (lock_v),
    .dir_v       (dir_v),
    .flt_v       (flt_v),
    .stat_v      (stat_v),
    .cfg_flat    (cfg_flat)
);

// File: tb/tb_gpio_wake_bank.sv
module tb_gpio_wake_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int AW = 5;
    localparam int A_DATA = NP;
    localparam int A_STAT = NP + 1;
    localparam int A_LVL  = NP + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic [NP-1:0] pin_in = '0;
    logic          supply_fail = 1'b0;
    logic [NP-1:0] pad_oe, pad_out, pad_pu;
    logic          irq, pme;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_wake_bank dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .pin_in (pin_in), .supply_fail (supply_fail), .pad_oe (pad_oe),
        .pad_out (pad_out), .pad_pu (pad_pu), .irq (irq), .pme (pme)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        rd_addr = AW'(a);
        #1;
        d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic dir, input logic [1:0] drv,
        input logic pu, input logic flt, input logic lock, input logic pol,
        input logic edg, input logic ie, input logic pe, input logic [3:0] dbn);
        return {dbn, 2'b00, pe, ie, edg, pol, lock, flt, pu, drv, dir};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        for (int a = 0; a < NP + 3; a++) begin
            rd(a, d);
            chk($sformatf("R1 reset read addr %0d", a), d, 0);
        end
        chk("R1 reset pad_oe", pad_oe, 0);
        chk("R1 reset pad_pu", pad_pu, 0);
        chk("R1 reset irq/pme", {irq, pme}, 0);

        // R2 drive sweep
        for (int i = 0; i < NP; i++) begin
            for (int dv = 0; dv < 4; dv++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [1:0] e;
                    wr(A_DATA, 16'(b) << i);
                    wr(i, mk(1, 2'(dv), 0, 0, 0, 0, 0, 0, 0, 0));
                    e = (dv == 0) ? {1'b1, 1'(b)} : (dv == 1) ? {~1'(b), 1'b0} : 2'b00;
                    chk($sformatf("R2 pin %0d drv %0d data %0d {oe,out}", i, dv, b),
                        {pad_oe[i], pad_out[i]}, e);
                end
            end
            wr(A_DATA, 16'hFFFF);
            wr(i, 16'h0000);
            chk($sformatf("R2 pin %0d input undriven", i), pad_oe[i], 0);
        end

        // R3 pull-up
        for (int i = 0; i < NP; i++) begin
            wr(i, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
            chk($sformatf("R3 pin %0d pull-up on input", i), pad_pu, 32'(1) << i);
            wr(i, mk(1, 2, 1, 0, 0, 0, 0, 0, 0, 0));
            chk($sformatf("R3 pin %0d pull-up off as output", i), pad_pu, 0);
            wr(i, 0);
        end

        // R4 float on supply fail
        for (int i = 0; i < NP; i++) begin
            wr(A_DATA, 16'(1) << i);
            wr(i, mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 0));
            supply_fail = 1'b1; #1;
            chk($sformatf("R4 pin %0d flagged floats", i), pad_oe[i], 0);
            supply_fail = 1'b0; #1;
            chk($sformatf("R4 pin %0d drives after fail", i), {pad_oe[i], pad_out[i]}, 2'b11);
            wr(i, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            supply_fail = 1'b1; #1;
            chk($sformatf("R4 pin %0d unflagged keeps driving", i), pad_oe[i], 1);
            supply_fail = 1'b0;
            wr(i, 0);
        end

        // R12 register map
        for (int i = 0; i < NP; i++) begin
            logic [15:0] p;
            p = {4'(i), 2'b11, 10'((i * 37) & 10'h3DF)};
            wr(i, p);
            rd(i, d);
            chk($sformatf("R12 cfg readback pin %0d", i), d, p & 16'hF3FF);
            wr(i, 0);
        end
        wr(A_DATA, 16'hA5C3);
        rd(A_DATA, d);
        chk("R12 data readback", d, 16'hA5C3);
        wr(A_DATA, 0);
        rd(25, d);
        chk("R12 unmapped reads 0", d, 0);

        // R6 debounce timing and glitch rejection
        for (int n = 0; n < 16; n++) begin
            int p, need;
            p = n;
            need = (n == 0) ? 1 : n;
            wr(p, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'(n)));
            pin_in[p] = 1'b1;
            repeat (need + 1) @(posedge clk);
            #1; rd(A_LVL, d);
            chk($sformatf("R6 N=%0d not yet accepted", n), d[p], 0);
            @(posedge clk);
            #1; rd(A_LVL, d);
            chk($sformatf("R6 N=%0d accepted on time", n), d[p], 1);
            @(negedge clk);
            pin_in[p] = 1'b0;
            cyc(need + 4);
            if (need >= 2) begin
                pin_in[p] = 1'b1;
                cyc(need - 1);
                pin_in[p] = 1'b0;
                cyc(need + 4);
                rd(A_LVL, d);
                chk($sformatf("R6 N=%0d short pulse ignored", n), d[p], 0);
            end
            wr(p, 0);
        end
        cyc(4);
        wr(A_STAT, 16'hFFFF);

        // R7 / R8 / R9 / R10 event sweep
        for (int i = 0; i < NP - 1; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic pol, edg, ie, pe;
                pol = c[0]; edg = c[1];
                ie = c[0] ^ i[0]; pe = c[1] ^ i[0];
                pin_in[i] = pol;
                wr(i, mk(0, 0, 0, 0, 0, pol, edg, ie, pe, 0));
                cyc(5);
                wr(A_STAT, 16'hFFFF);
                cyc(1);
                rd(A_STAT, d);
                chk($sformatf("R7 pin %0d c%0d inactive quiet", i, c), d, 0);
                chk($sformatf("R10 pin %0d c%0d no route idle", i, c), {irq, pme}, 0);
                pin_in[i] = ~pol;
                cyc(6);
                rd(A_STAT, d);
                chk($sformatf("R7 R8 pin %0d c%0d status set", i, c), d, 32'(1) << i);
                chk($sformatf("R10 pin %0d c%0d irq/pme", i, c), {irq, pme}, {ie, pe});
                wr(A_STAT, ~(16'(1) << i));
                rd(A_STAT, d);
                chk($sformatf("R9 pin %0d c%0d zero write keeps", i, c), d, 32'(1) << i);
                wr(A_STAT, 16'hFFFF);
                cyc(2);
                rd(A_STAT, d);
                chk($sformatf("R8 R9 pin %0d c%0d after clear while held", i, c),
                    d, edg ? 0 : (32'(1) << i));
                pin_in[i] = 1'b0;
                wr(i, 0);
                cyc(6);
                wr(A_STAT, 16'hFFFF);
                cyc(1);
                rd(A_STAT, d);
                chk($sformatf("R9 pin %0d c%0d cleared", i, c), d, 0);
            end
        end

        // R11 non-wake pin
        pin_in[NP-1] = 1'b0;
        wr(NP - 1, mk(0, 0, 0, 0, 0, 1, 0, 1, 1, 0));
        cyc(6);
        pin_in[NP-1] = 1'b1; cyc(6);
        pin_in[NP-1] = 1'b0; cyc(6);
        rd(A_STAT, d);
        chk("R11 non-wake status stays 0", d, 0);
        chk("R11 non-wake no irq/pme", {irq, pme}, 0);
        wr(NP - 1, 0);

        // R5 lock
        for (int i = 0; i < NP; i++) begin
            logic [15:0] lc;
            lc = mk(1, 0, 0, 0, 1, 0, 0, 0, 0, 0);
            wr(A_DATA, 16'(1) << i);
            wr(i, lc);
            wr(i, 0);
            rd(i, d);
            chk($sformatf("R5 pin %0d cfg write ignored", i), d, lc);
            wr(A_DATA, 0);
            chk($sformatf("R5 pin %0d data write ignored", i), {pad_oe[i], pad_out[i]}, 2'b11);
        end
        rd(A_DATA, d);
        chk("R5 data of all locked pins held", d, 16'hFFFF);
        @(negedge clk); rst_n = 1'b0;
        cyc(2); rst_n = 1'b1; cyc(1);
        rd(3, d);
        chk("R5 reset unlocks cfg", d, 0);
        chk("R5 reset releases pads", pad_oe, 0);
        wr(3, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
        rd(3, d);
        chk("R5 writes accepted after reset", d, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule